// File: doc/BRIEF.md
# Unaligned Transmit Byte Packer

This block sits between a 32-bit memory read path and a 36-bit transmit FIFO. A packet's payload can begin at any byte address, so the words arriving from memory carry the packet's first bytes in arbitrary lanes. The packer gathers the useful bytes, repacks them into whole 32-bit words with the packet's first byte in the lowest lane, and writes each full word into the FIFO under a data tag. The packet's final partial word is padded with zeros. An end-of-packet entry closes every packet and returns the packer to idle.

The transaction controller starts a packet with a one-cycle `start` pulse that carries the starting byte offset and the byte count. While the packer is idle, the controller can also write command words into the FIFO through the packer, and they pass through unchanged. When the controller reports that a transaction ended with a transmit underrun, the packer records that result. It drops any remaining payload and still writes the end-of-packet entry, so leftover bytes held in the aligner can never be merged into the next command word. A full FIFO stalls every kind of write without losing or repeating an entry.

Top module: `unaligned_tx_packer`

## Requirements
- R1: After reset, `fifo_wr` and `bus_ready` are 0, `start_ready` is 1, and `cmd_ready` is 1 while `fifo_full` is 0.
- R2: While idle, a command with `cmd_valid` high is written to the FIFO unchanged in the same cycle when `fifo_full` is 0, and `cmd_ready` equals the inverse of `fifo_full`.
- R3: While a packet is in progress, `start_ready` and `cmd_ready` are 0, no command word is written, and a `start` pulse has no effect on the packet being processed.
- R4: Packet byte i is the memory byte at address `start_off` + i, counted from the first memory word supplied. It is written to FIFO word i/4, lane i%4 (bits 8*(i%4)+7 down to 8*(i%4)). Every payload entry carries tag 0x2 in bits 35:32.
- R5: When the byte count is not a multiple of 4, the unused high lanes of the last payload word are zero.
- R6: After the last payload word, exactly one end-of-packet entry is written: tag 0x1 and a data field of 0. In the next cycle the packer is idle. A packet of length 0 produces only this entry.
- R7: When `xact_done` is high with `xact_status` = 2'b10 (underrun) while a packet is in progress, `bus_ready` is 0 from the next cycle. No further payload word is written, the end-of-packet entry follows, and a command written after it passes unchanged.
- R8: An underrun report while idle has no effect, and any other status code during a packet does not change that packet's output.
- R9: `fifo_wr` is never high while `fifo_full` is 1, and stalls neither drop nor repeat any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a packet (taken only while idle) |
| start_off | input | 2 | Byte offset of the first packet byte within the first memory word |
| start_len | input | LEN_W | Packet length in bytes |
| start_ready | output | 1 | Packer is idle and accepts `start` |
| bus_valid | input | 1 | Memory word present on `bus_data` |
| bus_data | input | 32 | Memory word, lowest address in bits 7:0 |
| bus_ready | output | 1 | Packer takes the memory word this cycle |
| xact_done | input | 1 | Transaction result is reported this cycle |
| xact_status | input | 2 | Transaction result code, 2'b10 = transmit underrun |
| cmd_valid | input | 1 | Command word offered for the FIFO |
| cmd_data | input | 36 | Command entry (tag and data) |
| cmd_ready | output | 1 | Command is accepted this cycle |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 36 | FIFO entry: tag in 35:32, data in 31:0 |
| fifo_full | input | 1 | FIFO cannot take an entry this cycle |

## Verification
Command pass-through and payload writes are combinational. A word that leaves the aligner appears on `fifo_wr` in the same cycle that its memory word, or its command, is accepted. The flush word and the end-of-packet entry each take one cycle after the state that produces them, and `start_ready` rises one cycle after the end-of-packet write. An underrun report lowers `bus_ready` one cycle later, and the end-of-packet entry follows in the cycle after that. The bench drives inputs at the falling edge and samples outputs one nanosecond later, ahead of the next rising edge. Each result is therefore read in the exact cycle it is due.

// File: rtl/utp_pkg.sv
// Shared constants and types for the unaligned transmit packer.
// Assumes a 32-bit memory word and a 4-bit tag above it in each FIFO entry.
package utp_pkg;
    localparam int DATA_W  = 32;
    localparam int BYTES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(BYTES);
    localparam int HOLD_W  = DATA_W - 8;
    localparam int TAG_W   = 4;
    localparam int ENTRY_W = TAG_W + DATA_W;
    localparam int ST_W    = 2;

    localparam logic [TAG_W-1:0] TAG_SOP  = 4'h0;
    localparam logic [TAG_W-1:0] TAG_EOP  = 4'h1;
    localparam logic [TAG_W-1:0] TAG_DATA = 4'h2;
    localparam logic [ST_W-1:0]  ST_UNDERRUN = 2'b10;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PACK,
        S_FLUSH,
        S_EOP
    } pk_state_e;
endpackage

// File: rtl/utp_merge.sv
// Byte merge network: joins the bytes held from earlier words with the
// useful bytes of the current memory word, and emits one full word when
// four or more bytes are available.
// Assumes hold is zero above hold_cnt bytes, and that rem is nonzero
// whenever the result is used.
module utp_merge
    import utp_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [HOLD_W-1:0] hold,
    input  logic [OFF_W-1:0]  hold_cnt,
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  off,
    input  logic [LEN_W-1:0]  rem,
    output logic [OFF_W:0]    take,
    output logic [DATA_W-1:0] out_word,
    output logic              out_full,
    output logic [HOLD_W-1:0] new_hold,
    output logic [OFF_W-1:0]  new_cnt
);
    localparam int MRG_W = DATA_W + HOLD_W;

    logic [OFF_W:0]    avail;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] fresh;
    logic [MRG_W-1:0]  merged;
    logic [OFF_W:0]    total;

    // Pick the useful bytes of the word and append them after the held bytes
    always_comb begin
        avail = (OFF_W+1)'(BYTES) - {1'b0, off};
        if (rem < LEN_W'(avail)) begin
            take = rem[OFF_W:0];
        end else begin
            take = avail;
        end
        shifted = word >> {off, 3'b000};
        for (int b = 0; b < BYTES; b++) begin
            fresh[8*b +: 8] = ((OFF_W+1)'(b) < take) ? shifted[8*b +: 8] : 8'h00;
        end
        merged   = {{DATA_W{1'b0}}, hold} | ({{HOLD_W{1'b0}}, fresh} << {hold_cnt, 3'b000});
        total    = {1'b0, hold_cnt} + take;
        out_full = (total >= (OFF_W+1)'(BYTES));
        out_word = merged[DATA_W-1:0];
        if (out_full) begin
            new_hold = merged[MRG_W-1:DATA_W];
            new_cnt  = OFF_W'(total - (OFF_W+1)'(BYTES));
        end else begin
            new_hold = merged[HOLD_W-1:0];
            new_cnt  = OFF_W'(total);
        end
    end
endmodule

// File: rtl/utp_seq.sv
// Packet sequencer: tracks the remaining byte count, the held partial
// bytes and the registered underrun flag, and walks
// idle -> pack -> (flush) -> end-of-packet -> idle.
// Assumes fifo_wr is the block's own write strobe, fed back from the output mux.
module utp_seq
    import utp_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  start_off,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              bus_fire,
    input  logic [OFF_W:0]    take,
    input  logic [HOLD_W-1:0] new_hold,
    input  logic [OFF_W-1:0]  new_cnt,
    input  logic              fifo_wr,
    input  logic              xact_done,
    input  logic [ST_W-1:0]   xact_status,
    output pk_state_e         state,
    output logic [HOLD_W-1:0] hold,
    output logic [OFF_W-1:0]  hold_cnt,
    output logic [LEN_W-1:0]  rem,
    output logic [OFF_W-1:0]  off_cur,
    output logic              abort_q
);
    // Register an underrun result; clear it once the closing tag is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else if (state == S_EOP && fifo_wr) begin
            abort_q <= 1'b0;
        end else if (state != S_IDLE && xact_done && xact_status == ST_UNDERRUN) begin
            abort_q <= 1'b1;
        end
    end

    // Advance the packet state and the alignment context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            hold     <= '0;
            hold_cnt <= '0;
            rem      <= '0;
            off_cur  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        off_cur  <= start_off;
                        rem      <= start_len;
                        hold     <= '0;
                        hold_cnt <= '0;
                        state    <= (start_len == '0) ? S_EOP : S_PACK;
                    end
                end
                S_PACK: begin
                    if (abort_q) begin
                        state <= S_EOP;
                    end else if (bus_fire) begin
                        hold     <= new_hold;
                        hold_cnt <= new_cnt;
                        rem      <= rem - LEN_W'(take);
                        off_cur  <= '0;
                        if (rem == LEN_W'(take)) begin
                            state <= (new_cnt != '0) ? S_FLUSH : S_EOP;
                        end
                    end
                end
                S_FLUSH: begin
                    if (abort_q || fifo_wr) begin
                        state <= S_EOP;
                    end
                end
                S_EOP: begin
                    if (fifo_wr) begin
                        state    <= S_IDLE;
                        hold     <= '0;
                        hold_cnt <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/utp_outmux.sv
// Output selector: picks the FIFO entry for the current state and
// produces the ready signals toward the memory path and the controller.
// Assumes a full FIFO blocks every write source in the same cycle.
module utp_outmux
    import utp_pkg::*;
(
    input  pk_state_e          state,
    input  logic               abort_q,
    input  logic               cmd_valid,
    input  logic [ENTRY_W-1:0] cmd_data,
    input  logic               fifo_full,
    input  logic               bus_valid,
    input  logic [DATA_W-1:0]  out_word,
    input  logic               out_full,
    input  logic [HOLD_W-1:0]  hold,
    output logic               fifo_wr,
    output logic [ENTRY_W-1:0] fifo_data,
    output logic               cmd_ready,
    output logic               bus_ready,
    output logic               bus_fire,
    output logic               start_ready
);
    // Select the write source and the handshakes per state
    always_comb begin
        fifo_wr     = 1'b0;
        fifo_data   = '0;
        cmd_ready   = 1'b0;
        bus_ready   = 1'b0;
        bus_fire    = 1'b0;
        start_ready = 1'b0;
        case (state)
            S_IDLE: begin
                start_ready = 1'b1;
                cmd_ready   = !fifo_full;
                fifo_wr     = cmd_valid && !fifo_full;
                fifo_data   = cmd_data;
            end
            S_PACK: begin
                bus_ready = !fifo_full && !abort_q;
                bus_fire  = bus_ready && bus_valid;
                fifo_wr   = bus_fire && out_full;
                fifo_data = {TAG_DATA, out_word};
            end
            S_FLUSH: begin
                fifo_wr   = !fifo_full && !abort_q;
                fifo_data = {TAG_DATA, {(DATA_W-HOLD_W){1'b0}}, hold};
            end
            S_EOP: begin
                fifo_wr   = !fifo_full;
                fifo_data = {TAG_EOP, {DATA_W{1'b0}}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/unaligned_tx_packer.sv
// Top of the unaligned transmit packer: realigns payload bytes that start
// at any byte offset into tagged 32-bit FIFO words, closes each packet
// with an end-of-packet entry (also after an underrun), and passes
// controller commands through while idle.
// Assumes start is only meaningful while start_ready is high.
module unaligned_tx_packer
    import utp_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [OFF_W-1:0]   start_off,
    input  logic [LEN_W-1:0]   start_len,
    output logic               start_ready,
    input  logic               bus_valid,
    input  logic [DATA_W-1:0]  bus_data,
    output logic               bus_ready,
    input  logic               xact_done,
    input  logic [ST_W-1:0]    xact_status,
    input  logic               cmd_valid,
    input  logic [ENTRY_W-1:0] cmd_data,
    output logic               cmd_ready,
    output logic               fifo_wr,
    output logic [ENTRY_W-1:0] fifo_data,
    input  logic               fifo_full
);
    pk_state_e         state;
    logic [HOLD_W-1:0] hold;
    logic [OFF_W-1:0]  hold_cnt;
    logic [LEN_W-1:0]  rem;
    logic [OFF_W-1:0]  off_cur;
    logic              abort_q;
    logic [OFF_W:0]    take;
    logic [DATA_W-1:0] out_word;
    logic              out_full;
    logic [HOLD_W-1:0] new_hold;
    logic [OFF_W-1:0]  new_cnt;
    logic              bus_fire;

    utp_merge #(.LEN_W(LEN_W)) u_merge (
        .hold     (hold),
        .hold_cnt (hold_cnt),
        .word     (bus_data),
        .off      (off_cur),
        .rem      (rem),
        .take     (take),
        .out_word (out_word),
        .out_full (out_full),
        .new_hold (new_hold),
        .new_cnt  (new_cnt)
    );

    utp_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_off   (start_off),
        .start_len   (start_len),
        .bus_fire    (bus_fire),
        .take        (take),
        .new_hold    (new_hold),
        .new_cnt     (new_cnt),
        .fifo_wr     (fifo_wr),
        .xact_done   (xact_done),
        .xact_status (xact_status),
        .state       (state),
        .hold        (hold),
        .hold_cnt    (hold_cnt),
        .rem         (rem),
        .off_cur     (off_cur),
        .abort_q     (abort_q)
    );

    utp_outmux u_outmux (
        .state       (state),
        .abort_q     (abort_q),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .fifo_full   (fifo_full),
        .bus_valid   (bus_valid),
        .out_word    (out_word),
        .out_full    (out_full),
        .hold        (hold),
        .fifo_wr     (fifo_wr),
        .fifo_data   (fifo_data),
        .cmd_ready   (cmd_ready),
        .bus_ready   (bus_ready),
        .bus_fire    (bus_fire),
        .start_ready (start_ready)
    );
endmodule

// File: rtl/utp_checker.sv
// Port-level protocol checks for the unaligned transmit packer,
// attached to every instance of the top through bind.
module utp_checker
    import utp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_ready,
    input logic               bus_ready,
    input logic               xact_done,
    input logic [ST_W-1:0]    xact_status,
    input logic               cmd_valid,
    input logic [ENTRY_W-1:0] cmd_data,
    input logic               cmd_ready,
    input logic               fifo_wr,
    input logic [ENTRY_W-1:0] fifo_data,
    input logic               fifo_full
);
    // R9
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    // R3
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ready |-> !cmd_ready);

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ready && cmd_valid && !fifo_full) |-> (fifo_wr && fifo_data == cmd_data));

    // R6
    eop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !start_ready && fifo_data[ENTRY_W-1:DATA_W] == TAG_EOP)
            |-> (fifo_data[DATA_W-1:0] == '0));

    // R6
    eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !start_ready && fifo_data[ENTRY_W-1:DATA_W] == TAG_EOP) |=> start_ready);

    // R7
    abort_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_done && xact_status == ST_UNDERRUN && !start_ready) |=> !bus_ready);
endmodule

bind unaligned_tx_packer utp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ready (start_ready),
    .bus_ready   (bus_ready),
    .xact_done   (xact_done),
    .xact_status (xact_status),
    .cmd_valid   (cmd_valid),
    .cmd_data    (cmd_data),
    .cmd_ready   (cmd_ready),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data),
    .fifo_full   (fifo_full)
);

// File: tb/unaligned_tx_packer_bench.sv
// Self-checking bench: a vector table of packets walked by one loop,
// then directed tests for reset, pass-through, blocking, underrun and idle cases.
module unaligned_tx_packer_bench;
    localparam int LEN_W = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  start_off = '0;
    logic [LEN_W-1:0] start_len = '0;
    logic        start_ready;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_data = '0;
    logic        bus_ready;
    logic        xact_done = 1'b0;
    logic [1:0]  xact_status = '0;
    logic        cmd_valid = 1'b0;
    logic [35:0] cmd_data = '0;
    logic        cmd_ready;
    logic        fifo_wr;
    logic [35:0] fifo_data;
    logic        fifo_full = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    unaligned_tx_packer #(.LEN_W(LEN_W)) u_unaligned_tx_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off),
        .start_len(start_len), .start_ready(start_ready), .bus_valid(bus_valid),
        .bus_data(bus_data), .bus_ready(bus_ready), .xact_done(xact_done),
        .xact_status(xact_status), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .fifo_full(fifo_full)
    );

    always #2 clk = ~clk;

    // Vector layout: {offset[15:14], stall[13], length[12:8], seed[7:0]}
    localparam logic [15:0] VEC [12] = '{
        {2'd0, 1'b0, 5'd8,  8'h10}, {2'd1, 1'b0, 5'd7,  8'h21},
        {2'd2, 1'b0, 5'd5,  8'h32}, {2'd3, 1'b0, 5'd1,  8'h43},
        {2'd3, 1'b0, 5'd9,  8'h54}, {2'd1, 1'b0, 5'd3,  8'h65},
        {2'd2, 1'b0, 5'd2,  8'h76}, {2'd0, 1'b0, 5'd13, 8'h87},
        {2'd3, 1'b0, 5'd13, 8'h98}, {2'd1, 1'b1, 5'd11, 8'ha9},
        {2'd2, 1'b1, 5'd6,  8'hba}, {2'd0, 1'b1, 5'd4,  8'hcb}
    };

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..: actual=%0d cycles expected=<50000", cycles);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bv(input int a, input logic [7:0] s);
        return 8'(a * 29 + int'(s) + 1);
    endfunction

    function automatic logic [31:0] memword(input int k, input logic [7:0] s);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[8*j +: 8] = bv(4*k + j, s);
        return w;
    endfunction

    function automatic logic [31:0] expword(input int off, input int len, input int w,
                                            input logic [7:0] s);
        logic [31:0] r;
        for (int j = 0; j < 4; j++) begin
            int i = 4*w + j;
            r[8*j +: 8] = (i < len) ? bv(off + i, s) : 8'h00;
        end
        return r;
    endfunction

    task automatic do_start(input int off, input int len);
        @(negedge clk);
        start = 1'b1;
        start_off = 2'(off);
        start_len = LEN_W'(len);
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // Feed the packet's memory words and check all entries it produces
    task automatic collect(input int off, input int len, input logic [7:0] s,
                           input bit stall, input bit okpulse);
        int nw = (len == 0) ? 0 : (off + len + 3) / 4;
        int ew = (len + 3) / 4;
        int k = 0;
        int ng = 0;
        bit done = 0;
        bit wfull = 0;
        bit fire;
        bit dok = 1;
        logic [3:0]  gt [16];
        logic [31:0] gd [16];
        for (int c = 0; c < 300 && !done; c++) begin
            @(negedge clk);
            fifo_full   = stall && (c % 3 == 1);
            bus_valid   = (k < nw);
            bus_data    = memword(k, s);
            xact_done   = okpulse && (c == 2);
            xact_status = 2'b01;
            #1;
            fire = bus_valid && bus_ready;
            if (fifo_wr) begin
                if (fifo_full) wfull = 1;
                if (ng < 16) begin
                    gt[ng] = fifo_data[35:32];
                    gd[ng] = fifo_data[31:0];
                end
                ng++;
                if (fifo_data[35:32] == 4'h1) done = 1;
            end
            @(posedge clk);
            if (fire) k++;
        end
        @(negedge clk);
        bus_valid = 1'b0;
        fifo_full = 1'b0;
        xact_done = 1'b0;
        #1;
        check(!wfull, "R9 write while full", 64'(wfull), 64'(0));
        check(ng == ew + 1 && ng <= 16, "R6 entry count", 64'(ng), 64'(ew + 1));
        if (ng == ew + 1 && ng <= 16) begin
            for (int w = 0; w < ew; w++) begin
                if (dok && (gt[w] != 4'h2 || gd[w] != expword(off, len, w, s))) begin
                    dok = 0;
                    check(0, "R4 payload word", {28'b0, gt[w], gd[w]},
                          {28'b0, 4'h2, expword(off, len, w, s)});
                end
            end
            if (dok) check(1, "R4 payload", 0, 0);
            if (len % 4 != 0) begin
                logic [31:0] m = 32'hffff_ffff << (8 * (len % 4));
                check((gd[ew-1] & m) == 0, "R5 padding", 64'(gd[ew-1] & m), 64'(0));
            end
            check(gt[ng-1] == 4'h1 && gd[ng-1] == 0, "R6 end tag",
                  {28'b0, gt[ng-1], gd[ng-1]}, {28'b0, 4'h1, 32'h0});
        end
        check(start_ready == 1'b1, "R6 idle after end", 64'(start_ready), 64'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1 reset state
        check(!fifo_wr && !bus_ready && start_ready && cmd_ready, "R1 reset state",
              {fifo_wr, bus_ready, start_ready, cmd_ready}, 4'b0011);
        @(negedge clk);
        rst_n = 1'b1;

        // Table-driven packets
        for (int v = 0; v < 12; v++) begin
            do_start(int'(VEC[v][15:14]), int'(VEC[v][12:8]));
            collect(int'(VEC[v][15:14]), int'(VEC[v][12:8]), VEC[v][7:0], VEC[v][13], 1'b0);
        end

        // R6 zero-length packet
        do_start(0, 0);
        collect(0, 0, 8'h01, 1'b0, 1'b0);

        // R2 idle pass-through, then with FIFO full
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 36'h0_1234_5678;
        #1;
        check(fifo_wr && fifo_data == cmd_data && cmd_ready, "R2 pass-through",
              {27'b0, fifo_wr, fifo_data}, {27'b0, 1'b1, cmd_data});
        @(negedge clk);
        fifo_full = 1'b1;
        #1;
        check(!fifo_wr && !cmd_ready, "R2 full blocks command", {fifo_wr, cmd_ready}, 2'b00);
        @(negedge clk);
        fifo_full = 1'b0;
        cmd_valid = 1'b0;

        // R3 commands and new starts held off while busy
        do_start(1, 6);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 36'h0_dead_beef;
        start = 1'b1;
        start_off = 2'd3;
        start_len = LEN_W'(2);
        #1;
        check(!cmd_ready && !fifo_wr && !start_ready, "R3 busy blocks command",
              {cmd_ready, fifo_wr, start_ready}, 3'b000);
        @(posedge clk);
        #1;
        start = 1'b0;
        cmd_valid = 1'b0;
        collect(1, 6, 8'h5a, 1'b0, 1'b0);

        // R7 underrun abort
        do_start(1, 12);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_data  = memword(0, 8'h40);
        @(posedge clk);
        @(negedge clk);
        bus_valid   = 1'b0;
        xact_done   = 1'b1;
        xact_status = 2'b10;
        @(posedge clk);
        @(negedge clk);
        xact_done = 1'b0;
        bus_valid = 1'b1;
        bus_data  = memword(1, 8'h40);
        #1;
        check(!bus_ready && !fifo_wr, "R7 payload stops", {bus_ready, fifo_wr}, 2'b00);
        @(posedge clk);
        @(negedge clk);
        #1;
        check(fifo_wr && fifo_data == {4'h1, 32'h0}, "R7 end tag after underrun",
              {27'b0, fifo_wr, fifo_data}, {27'b0, 1'b1, 4'h1, 32'h0});
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        cmd_valid = 1'b1;
        cmd_data  = 36'h0_0300_2910;
        #1;
        check(start_ready, "R7 idle after abort", 64'(start_ready), 64'(1));
        check(fifo_wr && fifo_data == 36'h0_0300_2910, "R7 clean command",
              {27'b0, fifo_wr, fifo_data}, {27'b0, 1'b1, 36'h0_0300_2910});
        @(negedge clk);
        cmd_valid = 1'b0;

        // R8 underrun while idle has no effect
        xact_done   = 1'b1;
        xact_status = 2'b10;
        @(negedge clk);
        xact_done = 1'b0;
        #1;
        check(start_ready && !fifo_wr, "R8 idle underrun ignored", {start_ready, fifo_wr}, 2'b10);
        @(negedge clk);
        #1;
        check(!fifo_wr && !bus_ready, "R8 no stray entry", {fifo_wr, bus_ready}, 2'b00);

        // R8 non-underrun status during a packet
        do_start(2, 10);
        collect(2, 10, 8'h77, 1'b0, 1'b1);

        summary_and_end();
    end
endmodule